// File: doc/BRIEF.md
# Capability Special-Register Move Unit

This block carries out two instructions that copy an opaque capability word between the general capability register file and a bank of special capability registers. One instruction reads a special register into a general register. The other writes a general register into a special register. Each instruction word comes with the current privilege state:

- the exception-level and error-level status bits,
- a two-bit mode field,
- a permission flag taken from the program-counter capability,
- a coprocessor-usable flag,
- a 32-bit mask of inaccessible general registers.

The unit decodes the word and looks up the selector. It runs the access checks in a fixed priority order. It then either raises a one-cycle exception or performs the move.

Most special registers share storage with general registers. These are reached through the unit's single register-file read port and single write port. Two thread-local registers are held inside the unit.

The instruction interface is a plain valid strobe with no ready signal and no back-pressure. A word is accepted in every cycle that `instr_valid` is high. The whole instruction completes combinationally in that cycle:

- The exception outputs and the register-file write request are valid in the same cycle as the instruction.
- The external file and the internal registers update at the following rising edge.

So back-to-back instructions see each other's results without a hazard. Capability contents are never interpreted.

Top module: `capsr_unit`

## Requirements
- R1: A word is acted on only when `instr_valid` is high, bits [31:26]=6'b010010, bits [25:21]=0, bits [5:0]=6'b111111, and bits [10:6] are 5'd13 (read-special) or 5'd14 (write-special). Bits [20:16] name the general register and bits [15:11] the selector. Any other word raises no exception and requests no write.
- R2: The known selectors are 0, 1, 8, 22, 23, 29, 30 and 31. Selectors 0, 22, 23, 29, 30 and 31 alias general registers 0, 27, 28, 29, 30 and 31 respectively. Selectors 1 and 8 are two registers held inside the unit.
- R3: An unknown selector raises cause 10 with reported register 0.
- R4: When `cop_usable` is low, every recognised word raises cause 11 with reported register 0. This check wins over all others.
- R5: After the selector check, a general register whose bit is set in `inacc_mask` raises cause 24 and reports that general register's number. This check wins over the permission and privilege checks.
- R6: Selectors 0 and 1 need nothing. Selector 8 needs `pcc_sysreg_ok`. Selectors 22 and 23 need supervisor level or above. Selectors 29, 30 and 31 need both. A missing permission or an insufficient level raises cause 24 and reports the selector number.
- R7: The level is kernel (2) whenever `status_exl` or `status_erl` is set. Otherwise `priv_mode` 2'b00 is user (0), 2'b01 is supervisor (1), and 2'b10 or 2'b11 is kernel (2). Access is granted when the level is at least the required one.
- R8: A successful read-special drives a write of the selected special value to the named general register in the same cycle.
- R9: A successful write-special copies the named general register into the aliased general register, or into the internal register. A later read of that selector returns the value.
- R10: Whenever an exception is raised, no register-file write is requested and the internal registers keep their values.
- R11: Reset clears both internal registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| status_exl | input | 1 | Exception-level status bit |
| status_erl | input | 1 | Error-level status bit |
| priv_mode | input | 2 | Mode field (00 user, 01 supervisor, else kernel) |
| pcc_sysreg_ok | input | 1 | Program-counter capability grants system-register access |
| cop_usable | input | 1 | Capability coprocessor enabled |
| inacc_mask | input | 32 | Per-general-register inaccessible flags |
| rf_rd_addr | output | 5 | Register-file read address |
| rf_rd_data | input | CAP_W | Register-file read data (combinational) |
| rf_wr_en | output | 1 | Register-file write request |
| rf_wr_addr | output | 5 | Register-file write address |
| rf_wr_data | output | CAP_W | Register-file write data |
| exc_valid | output | 1 | Exception raised this cycle |
| exc_cause | output | 5 | Exception cause code (10, 11 or 24) |
| exc_reg | output | 5 | Offending register or selector number |

## Verification
Each kind of internal fault shows at the ports within a known time:

- A corrupted internal thread-local register does not show at once. It appears at the ports only on the next successful read of selector 1 or 8, as wrong data on `rf_wr_data`.
- The bench therefore reads those selectors often and also compares the whole modelled register file at the end.
- A wrong selector entry or priority decision is visible in the same cycle as the instruction, on `exc_cause`, `exc_reg` or `rf_wr_addr`.
- The bench predicts all of these for every selector, privilege level and permission setting.

// File: rtl/capsr_pkg.sv
package capsr_pkg;
  localparam int SEL_W   = 5;
  localparam int N_DED   = 2;
  localparam int DED_IW  = 1;

  localparam logic [4:0] CAUSE_RESV   = 5'd10;
  localparam logic [4:0] CAUSE_COPOFF = 5'd11;
  localparam logic [4:0] CAUSE_SYSREG = 5'd24;

  typedef enum logic [1:0] {
    LVL_USER = 2'd0,
    LVL_SUP  = 2'd1,
    LVL_KERN = 2'd2
  } lvl_e;

  typedef struct packed {
    logic              known;
    logic              need_sup;
    logic              need_sys;
    logic              aliased;
    logic [SEL_W-1:0]  gpr;
    logic [DED_IW-1:0] ded;
  } sel_info_t;

  function automatic sel_info_t sel_lookup(input logic [SEL_W-1:0] s);
    sel_info_t r;
    r = '0;
    case (s)
      5'd0:  begin r.known = 1'b1; r.aliased = 1'b1; r.gpr = 5'd0; end
      5'd1:  begin r.known = 1'b1; r.ded = 1'b0; end
      5'd8:  begin r.known = 1'b1; r.need_sys = 1'b1; r.ded = 1'b1; end
      5'd22: begin r.known = 1'b1; r.need_sup = 1'b1; r.aliased = 1'b1; r.gpr = 5'd27; end
      5'd23: begin r.known = 1'b1; r.need_sup = 1'b1; r.aliased = 1'b1; r.gpr = 5'd28; end
      5'd29, 5'd30, 5'd31: begin
        r.known = 1'b1; r.need_sup = 1'b1; r.need_sys = 1'b1;
        r.aliased = 1'b1; r.gpr = s;
      end
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/capsr_decode.sv
module capsr_decode
  import capsr_pkg::*;
(
  input  logic             instr_valid,
  input  logic [31:0]      instr,
  output logic             hit,
  output logic             is_read,
  output logic [SEL_W-1:0] creg,
  output logic [SEL_W-1:0] sel
);
  localparam logic [5:0] MAJOR   = 6'b010010;
  localparam logic [4:0] SUBOP   = 5'b00000;
  localparam logic [5:0] TAIL    = 6'b111111;
  localparam logic [4:0] FN_READ = 5'd13;
  localparam logic [4:0] FN_WRIT = 5'd14;

  logic       frame_ok;
  logic [4:0] fn;

  assign fn       = instr[10:6];
  assign frame_ok = (instr[31:26] == MAJOR) && (instr[25:21] == SUBOP) && (instr[5:0] == TAIL);
  assign hit      = instr_valid && frame_ok && ((fn == FN_READ) || (fn == FN_WRIT));
  assign is_read  = (fn == FN_READ);
  assign creg     = instr[20:16];
  assign sel      = instr[15:11];
endmodule

// File: rtl/capsr_guard.sv
module capsr_guard
  import capsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             cop_usable,
  input  logic             known,
  input  logic             need_sup,
  input  logic             need_sys,
  input  logic [SEL_W-1:0] creg,
  input  logic [SEL_W-1:0] sel,
  input  logic [31:0]      inacc_mask,
  input  logic             status_exl,
  input  logic             status_erl,
  input  logic [1:0]       priv_mode,
  input  logic             pcc_sysreg_ok,
  output logic             fault,
  output logic [4:0]       cause,
  output logic [SEL_W-1:0] culprit
);
  lvl_e level;

  always_comb begin
    if (status_exl || status_erl)  level = LVL_KERN;
    else if (priv_mode == 2'b00)   level = LVL_USER;
    else if (priv_mode == 2'b01)   level = LVL_SUP;
    else                           level = LVL_KERN;
  end

  logic sup_ok;
  assign sup_ok = (level >= LVL_SUP);

  always_comb begin
    fault   = 1'b0;
    cause   = '0;
    culprit = '0;
    if (!cop_usable) begin
      fault = 1'b1; cause = CAUSE_COPOFF;
    end else if (!known) begin
      fault = 1'b1; cause = CAUSE_RESV;
    end else if (inacc_mask[creg]) begin
      fault = 1'b1; cause = CAUSE_SYSREG; culprit = creg;
    end else if (need_sys && !pcc_sysreg_ok) begin
      fault = 1'b1; cause = CAUSE_SYSREG; culprit = sel;
    end else if (need_sup && !sup_ok) begin
      fault = 1'b1; cause = CAUSE_SYSREG; culprit = sel;
    end
  end

  a_r4_cop_first: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cop_usable) |-> (fault && cause == CAUSE_COPOFF && culprit == '0));

  a_r5_inacc_names_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cop_usable && known && inacc_mask[creg]) |-> (fault && culprit == creg));

  a_r6_open_selectors: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cop_usable && (sel == 5'd0 || sel == 5'd1) && !inacc_mask[creg]) |-> !fault);

  a_r7_kernel_by_status: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cop_usable && known && !inacc_mask[creg] && (status_exl || status_erl) && pcc_sysreg_ok)
      |-> !fault);
endmodule

// File: rtl/capsr_tls_bank.sv
module capsr_tls_bank #(
  parameter int CAP_W  = 64,
  parameter int N_DED  = 2,
  parameter int IDX_W  = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [CAP_W-1:0]            wr_data,
  output logic [N_DED-1:0][CAP_W-1:0] q
);
  for (genvar i = 0; i < N_DED; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              q[i] <= '0;
      else if (wr_en && (int'(wr_idx) == i))   q[i] <= wr_data;
    end
  end

  a_r10_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/capsr_unit.sv
module capsr_unit
  import capsr_pkg::*;
#(
  parameter int CAP_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  input  logic [31:0]      instr,
  input  logic             status_exl,
  input  logic             status_erl,
  input  logic [1:0]       priv_mode,
  input  logic             pcc_sysreg_ok,
  input  logic             cop_usable,
  input  logic [31:0]      inacc_mask,
  output logic [4:0]       rf_rd_addr,
  input  logic [CAP_W-1:0] rf_rd_data,
  output logic             rf_wr_en,
  output logic [4:0]       rf_wr_addr,
  output logic [CAP_W-1:0] rf_wr_data,
  output logic             exc_valid,
  output logic [4:0]       exc_cause,
  output logic [4:0]       exc_reg
);
  logic             hit, is_read;
  logic [SEL_W-1:0] creg, sel;
  sel_info_t        info;
  logic             fault;
  logic [4:0]       cause;
  logic [SEL_W-1:0] culprit;
  logic             go, ded_wr;
  logic [CAP_W-1:0] special_val;
  logic [N_DED-1:0][CAP_W-1:0] ded_q;

  capsr_decode u_dec (
    .instr_valid (instr_valid),
    .instr       (instr),
    .hit         (hit),
    .is_read     (is_read),
    .creg        (creg),
    .sel         (sel)
  );

  assign info = sel_lookup(sel);

  capsr_guard u_guard (
    .clk           (clk),
    .rst_n         (rst_n),
    .hit           (hit),
    .cop_usable    (cop_usable),
    .known         (info.known),
    .need_sup      (info.need_sup),
    .need_sys      (info.need_sys),
    .creg          (creg),
    .sel           (sel),
    .inacc_mask    (inacc_mask),
    .status_exl    (status_exl),
    .status_erl    (status_erl),
    .priv_mode     (priv_mode),
    .pcc_sysreg_ok (pcc_sysreg_ok),
    .fault         (fault),
    .cause         (cause),
    .culprit       (culprit)
  );

  assign go          = hit && !fault && info.known;
  assign rf_rd_addr  = is_read ? info.gpr : creg;
  assign special_val = info.aliased ? rf_rd_data : ded_q[info.ded];
  assign rf_wr_en    = go && (is_read || info.aliased);
  assign rf_wr_addr  = is_read ? creg : info.gpr;
  assign rf_wr_data  = is_read ? special_val : rf_rd_data;
  assign ded_wr      = go && !is_read && !info.aliased;

  assign exc_valid = hit && fault;
  assign exc_cause = exc_valid ? cause   : '0;
  assign exc_reg   = exc_valid ? culprit : '0;

  capsr_tls_bank #(
    .CAP_W (CAP_W),
    .N_DED (N_DED),
    .IDX_W (DED_IW)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ded_wr),
    .wr_idx  (info.ded),
    .wr_data (rf_rd_data),
    .q       (ded_q)
  );

  a_r10_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (!rf_wr_en && !ded_wr));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> (!exc_valid && !rf_wr_en));

  a_r8_read_target: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr_en && is_read) |-> (rf_wr_addr == creg));

  a_r3_resv_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cop_usable && !info.known) |-> (exc_valid && exc_cause == CAUSE_RESV));
endmodule

// File: tb/capsr_unit_bench.sv
`timescale 1ns/1ps
module capsr_unit_bench;
  localparam int CAP_W = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             instr_valid = 1'b0;
  logic [31:0]      instr = '0;
  logic             status_exl = 1'b0, status_erl = 1'b0;
  logic [1:0]       priv_mode = 2'b00;
  logic             pcc_sysreg_ok = 1'b0, cop_usable = 1'b1;
  logic [31:0]      inacc_mask = '0;
  logic [4:0]       rf_rd_addr, rf_wr_addr, exc_cause, exc_reg;
  logic [CAP_W-1:0] rf_rd_data, rf_wr_data;
  logic             rf_wr_en, exc_valid;

  logic [CAP_W-1:0] fgpr [32];
  logic [CAP_W-1:0] mgpr [32];
  logic [CAP_W-1:0] mded [2];

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  capsr_unit #(.CAP_W(CAP_W)) u_capsr_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .status_exl(status_exl), .status_erl(status_erl), .priv_mode(priv_mode),
    .pcc_sysreg_ok(pcc_sysreg_ok), .cop_usable(cop_usable), .inacc_mask(inacc_mask),
    .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en),
    .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data), .exc_valid(exc_valid),
    .exc_cause(exc_cause), .exc_reg(exc_reg)
  );

  assign rf_rd_data = fgpr[rf_rd_addr];
  always @(posedge clk) if (rf_wr_en) fgpr[rf_wr_addr] <= rf_wr_data;

  task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int fn, input int cr, input int s);
    return {6'b010010, 5'b00000, 5'(cr), 5'(s), 5'(fn), 6'b111111};
  endfunction

  task automatic issue(input logic v, input logic [31:0] w, input logic cop,
                       input logic exl, input logic erl, input logic [1:0] mode,
                       input logic sys, input logic [31:0] mask);
    int fn, cr, s, lvl, aidx, d;
    bit hitE, known, nsup, nsys, alias_s, eexc, ewen;
    int ecause, ereg, eaddr;
    logic [63:0] edata;
    string tag;
    @(posedge clk); #1;
    instr_valid = v; instr = w; cop_usable = cop; status_exl = exl; status_erl = erl;
    priv_mode = mode; pcc_sysreg_ok = sys; inacc_mask = mask;
    fn = int'(w[10:6]); cr = int'(w[20:16]); s = int'(w[15:11]);
    hitE = v && w[31:26] == 6'b010010 && w[25:21] == 5'd0 && w[5:0] == 6'h3f && (fn == 13 || fn == 14);
    lvl = (exl || erl) ? 2 : (mode == 2'b00 ? 0 : (mode == 2'b01 ? 1 : 2));
    known = 0; nsup = 0; nsys = 0; alias_s = 0; aidx = 0; d = 0;
    case (s)
      0:  begin known = 1; alias_s = 1; aidx = 0; end
      1:  begin known = 1; d = 0; end
      8:  begin known = 1; nsys = 1; d = 1; end
      22: begin known = 1; nsup = 1; alias_s = 1; aidx = 27; end
      23: begin known = 1; nsup = 1; alias_s = 1; aidx = 28; end
      29, 30, 31: begin known = 1; nsup = 1; nsys = 1; alias_s = 1; aidx = s; end
      default: ;
    endcase
    eexc = 0; ewen = 0; ecause = 0; ereg = 0; eaddr = 0; edata = '0; tag = "R1";
    if (!hitE) tag = "R1";
    else if (!cop) begin eexc = 1; ecause = 11; tag = "R4"; end
    else if (!known) begin eexc = 1; ecause = 10; tag = "R3"; end
    else if (mask[cr]) begin eexc = 1; ecause = 24; ereg = cr; tag = "R5"; end
    else if (nsys && !sys) begin eexc = 1; ecause = 24; ereg = s; tag = "R6"; end
    else if (nsup && lvl < 1) begin eexc = 1; ecause = 24; ereg = s; tag = "R7"; end
    else if (fn == 13) begin
      ewen = 1; eaddr = cr; edata = alias_s ? mgpr[aidx] : mded[d]; tag = "R8";
    end else if (alias_s) begin
      ewen = 1; eaddr = aidx; edata = mgpr[cr]; tag = "R9";
    end else tag = "R9";
    @(negedge clk);
    cmp(tag, "exc_valid", 64'(exc_valid), 64'(eexc));
    if (eexc) begin
      cmp(tag, "exc_cause", 64'(exc_cause), 64'(ecause));
      cmp(tag, "exc_reg", 64'(exc_reg), 64'(ereg));
    end
    cmp(eexc ? "R10" : tag, "rf_wr_en", 64'(rf_wr_en), 64'(ewen));
    if (ewen) begin
      cmp(tag, "rf_wr_addr", 64'(rf_wr_addr), 64'(eaddr));
      cmp(tag, "rf_wr_data", rf_wr_data, edata);
    end
    if (ewen) mgpr[eaddr] = edata;
    if (hitE && !eexc && fn == 14 && !alias_s) mded[d] = mgpr[cr];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      fgpr[i] = {32'hCAB0_0000 | 32'(i), 32'(i * 32'h0101_0011)};
      mgpr[i] = fgpr[i];
    end
    mded[0] = '0; mded[1] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // reset state: idle outputs, R11 internal registers zero
    @(negedge clk);
    cmp("R1", "idle exc_valid", 64'(exc_valid), 64'd0);
    cmp("R1", "idle rf_wr_en", 64'(rf_wr_en), 64'd0);
    issue(1, mk(13, 5, 1), 1, 0, 0, 2'b10, 1, '0);   // R11 read sel 1
    issue(1, mk(13, 6, 8), 1, 0, 0, 2'b10, 1, '0);   // R11 read sel 8
    // R1 non-matching words
    issue(0, mk(13, 3, 0), 1, 0, 0, 2'b10, 1, '0);
    issue(1, mk(7, 3, 0), 1, 0, 0, 2'b10, 1, '0);
    issue(1, mk(13, 3, 0) ^ 32'h0400_0000, 1, 0, 0, 2'b10, 1, '0);
    issue(1, mk(14, 3, 0) | 32'h0020_0000, 1, 0, 0, 2'b10, 1, '0);
    issue(1, mk(13, 3, 0) ^ 32'h0000_0001, 1, 0, 0, 2'b10, 1, '0);
    // R2 R6 R7 R8 R9 sweep: every selector, level, permission, operation
    for (int s = 0; s < 32; s++)
      for (int lv = 0; lv < 5; lv++)
        for (int sy = 0; sy < 2; sy++)
          for (int op = 0; op < 2; op++) begin
            int cr;
            cr = (s * 3 + lv * 5 + sy * 11 + op * 7 + 1) % 32;
            issue(1, mk(op ? 14 : 13, cr, s), 1, lv == 3, lv == 4,
                  (lv == 3 || lv == 4) ? 2'b00 : 2'(lv), sy[0], '0);
          end
    // R9 round trip through internal registers
    issue(1, mk(14, 12, 1), 1, 0, 0, 2'b00, 0, '0);
    issue(1, mk(13, 13, 1), 1, 0, 0, 2'b00, 0, '0);
    issue(1, mk(14, 14, 8), 1, 0, 0, 2'b11, 1, '0);
    issue(1, mk(13, 15, 8), 1, 0, 0, 2'b11, 1, '0);
    // R4 priority over reserved selector and mask
    issue(1, mk(13, 4, 5), 0, 0, 0, 2'b00, 0, 32'hFFFF_FFFF);
    issue(1, mk(14, 4, 31), 0, 1, 0, 2'b10, 1, '0);
    // R3 reserved selector wins over mask
    issue(1, mk(13, 9, 2), 1, 0, 0, 2'b10, 1, 32'hFFFF_FFFF);
    // R5 mask wins over permission and level; reports general register
    issue(1, mk(13, 9, 31), 1, 0, 0, 2'b00, 0, 32'h0000_0200);
    issue(1, mk(14, 17, 0), 1, 0, 0, 2'b00, 0, 32'h0002_0000);
    issue(1, mk(13, 9, 31), 1, 0, 0, 2'b00, 0, 32'h0000_0400);  // other bit: R6 by selector
    // R10 failed write leaves internal register unchanged, then read back
    issue(1, mk(14, 20, 8), 1, 0, 0, 2'b10, 0, '0);
    issue(1, mk(13, 21, 8), 1, 0, 0, 2'b10, 1, '0);
    // R7 error-level bit alone grants supervisor selectors
    issue(1, mk(13, 2, 22), 1, 0, 1, 2'b00, 0, '0);
    // end: whole register file must match model (R9)
    @(posedge clk); #1 instr_valid = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 32; i++) cmp("R9", $sformatf("gpr[%0d]", i), fgpr[i], mgpr[i]);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule